// File: doc/BRIEF.md
# Standard-Basis Code-Division Channel Codec

This block lets a group of senders share one single-bit channel by code division, using the cheapest orthogonal code set there is: the standard basis. Sender i owns a code of length NSRC with one 1, at chip position i. A data bit is spread by ANDing it with that code, so in any chip period at most one sender puts a nonzero chip on the channel. The channel sum then reduces to an XOR across all sender chips. Each receiver ANDs the channel chip with the code of the source it listens to and folds the result into one single-bit accumulator. No comparator stage is needed. The chip rate equals the clock rate, so one symbol occupies NSRC cycles.

Each sender offers one bit per symbol on a valid/ready interface. One shared `in_ready` serves every sender. In a cycle where `in_ready` is high and at least one `in_valid` bit is set, all senders that assert `in_valid` are taken together as one symbol. A sender whose bit is not taken keeps `in_valid` and `in_data` steady until a later accepting cycle. While a symbol is being spread, `in_ready` stays low. It rises again in the last chip cycle, so symbols can follow each other with no gap. Every receiver has a source selection, sampled in the accepting cycle. Each receiver reports its decoded bit with a one-cycle `out_valid` pulse. The output side has no back-pressure: the consumer must take the pulse in the cycle it appears.

Top module: `sbc_codec`

## Requirements
- R1: After reset, and whenever no symbol is being spread, `in_ready` is 1. A cycle with `in_ready` and any `in_valid` bit set accepts a symbol. `in_ready` is then 0 for the next NSRC-1 cycles and returns to 1 in the last chip cycle of that symbol.
- R2: Sender i's spread chip can be nonzero only at chip position i of a symbol (code = one-hot vector, bit i set). At most one sender chip is nonzero in any cycle.
- R3: The channel chip is the XOR of all sender chips. Because the codes are one-hot, it always equals their OR.
- R4: A receiver whose selection field (bits r*SW +: SW of `rx_sel`) holds j outputs on `out_data[r]` the `in_data[j]` value that sender j offered in the accepting cycle.
- R5: `out_valid[r]` rises exactly NSRC+3 clock edges after the edge that accepted the symbol.
- R6: `out_valid[r]` pulses for one cycle per symbol, and only if the selected sender's `in_valid` bit was set in the accepting cycle. The `in_data` of a sender that was not valid has no effect on any output.
- R7: `rx_sel` is sampled only in the accepting cycle. Changes during the symbol's spreading do not alter that symbol's result.
- R8: Symbols accepted back to back, one every NSRC cycles, are each decoded correctly, and their outputs appear NSRC cycles apart with no mixing between symbols.
- R9: While `rst_n` is low, `out_valid` is all zeros and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one chip per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NSRC | Per-sender bit-offer valid |
| in_data | input | NSRC | Per-sender data bit |
| in_ready | output | 1 | Shared accept signal for all senders |
| rx_sel | input | NDST*SW | Per-receiver source index, SW = clog2(NSRC) bits each |
| out_valid | output | NDST | Per-receiver decoded-bit pulse |
| out_data | output | NDST | Per-receiver decoded bit |

## Verification
The bench assigns all senders to all receivers in every permutation while every sender is active. A design that let code chips overlap, or extracted at the wrong chip position, would return a neighbour's bit there. Symbols are driven back to back and the selections are scrambled right after each acceptance. This catches an accumulator that is not cleared at chip 0, which would fold the previous symbol in, and a selection that is read live instead of sampled. Random valid masks with garbage data on idle senders show whether a design pulses for a silent source or lets its data leak. A directed count of `in_ready` cycles after one acceptance pins the reopen point at the last chip.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Framing flags carried alongside each chip through the pipeline.
  typedef struct packed {
    logic vld;    // a chip of an accepted symbol occupies this stage
    logic first;  // chip position 0
    logic last;   // chip position NSRC-1
  } chip_tag_t;

  // One bit of a standard-basis code: the owner's chip is its own index.
  function automatic logic basis_chip(input int unsigned owner, input int unsigned chip);
    return owner == chip;
  endfunction

endpackage

// File: rtl/sbc_spreader.sv
module sbc_spreader
  import sbc_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NDST = 4,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      in_valid,
  input  logic [NSRC-1:0]      in_data,
  output logic                 in_ready,
  input  logic [NDST*SW-1:0]   rx_sel,
  output chip_tag_t            sp_tag,
  output logic [SW-1:0]        sp_idx,
  output logic [NSRC-1:0]      sp_chips,
  output logic [NSRC-1:0]      sp_vmask,
  output logic [NDST*SW-1:0]   sp_sel
);

  localparam logic [SW-1:0] LAST_POS = SW'(NSRC - 1);

  logic                busy;
  logic [SW-1:0]       pos;
  logic [NSRC-1:0]     hold_data;
  logic [NSRC-1:0]     hold_vld;
  logic [NDST*SW-1:0]  hold_sel;
  logic                at_last;
  logic                accept;
  logic [NSRC-1:0]     chips_c;

  assign at_last  = busy && (pos == LAST_POS);
  assign in_ready = !busy || at_last;
  assign accept   = in_ready && (|in_valid);

  // Spreading: AND of each sender's held bit with its one-hot code chip.
  for (genvar i = 0; i < NSRC; i++) begin : g_spread
    assign chips_c[i] = busy & hold_vld[i] & hold_data[i] & basis_chip(i, int'(pos));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pos       <= '0;
      hold_data <= '0;
      hold_vld  <= '0;
      hold_sel  <= '0;
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        pos       <= '0;
        hold_data <= in_data;
        hold_vld  <= in_valid;
        hold_sel  <= rx_sel;
      end else if (at_last) begin
        busy <= 1'b0;
      end else if (busy) begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_tag   <= '0;
      sp_idx   <= '0;
      sp_chips <= '0;
      sp_vmask <= '0;
      sp_sel   <= '0;
    end else begin
      sp_tag.vld   <= busy;
      sp_tag.first <= busy && (pos == '0);
      sp_tag.last  <= at_last;
      sp_idx       <= pos;
      sp_chips     <= chips_c;
      sp_vmask     <= hold_vld;
      sp_sel       <= hold_sel;
    end
  end

endmodule

// File: rtl/sbc_channel.sv
module sbc_channel
  import sbc_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NDST = 4,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  chip_tag_t           sp_tag,
  input  logic [SW-1:0]       sp_idx,
  input  logic [NSRC-1:0]     sp_chips,
  input  logic [NSRC-1:0]     sp_vmask,
  input  logic [NDST*SW-1:0]  sp_sel,
  output chip_tag_t           ch_tag,
  output logic [SW-1:0]       ch_idx,
  output logic                ch_bit,
  output logic [NSRC-1:0]     ch_vmask,
  output logic [NDST*SW-1:0]  ch_sel
);

  // Sum stage: with one-hot codes the multi-bit adder collapses to an XOR.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_tag   <= '0;
      ch_idx   <= '0;
      ch_bit   <= 1'b0;
      ch_vmask <= '0;
      ch_sel   <= '0;
    end else begin
      ch_tag   <= sp_tag;
      ch_idx   <= sp_idx;
      ch_bit   <= ^sp_chips;
      ch_vmask <= sp_vmask;
      ch_sel   <= sp_sel;
    end
  end

endmodule

// File: rtl/sbc_despreader.sv
module sbc_despreader
  import sbc_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chip_tag_t        ch_tag,
  input  logic [SW-1:0]    ch_idx,
  input  logic             ch_bit,
  input  logic [NSRC-1:0]  ch_vmask,
  input  logic [SW-1:0]    sel,
  output logic             out_valid,
  output logic             out_data
);

  chip_tag_t ex_tag;
  logic      ex_bit;
  logic      ex_srcv;
  logic      acc;
  logic      code_hit;

  assign code_hit = basis_chip(int'(sel), int'(ch_idx));

  // Extract stage: AND of channel chip with the selected source's code chip.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_tag  <= '0;
      ex_bit  <= 1'b0;
      ex_srcv <= 1'b0;
    end else begin
      ex_tag  <= ch_tag;
      ex_bit  <= ch_bit & code_hit;
      ex_srcv <= ch_vmask[sel];
    end
  end

  // Accumulate stage: a single one-bit register, restarted at chip 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (ex_tag.vld) acc <= ex_tag.first ? ex_bit : (acc ^ ex_bit);
      out_valid <= ex_tag.vld & ex_tag.last & ex_srcv;
    end
  end

  assign out_data = acc;

endmodule

// File: rtl/sbc_codec.sv
module sbc_codec
  import sbc_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int NDST = 4,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     in_valid,
  input  logic [NSRC-1:0]     in_data,
  output logic                in_ready,
  input  logic [NDST*SW-1:0]  rx_sel,
  output logic [NDST-1:0]     out_valid,
  output logic [NDST-1:0]     out_data
);

  chip_tag_t           sp_tag;
  logic [SW-1:0]       sp_idx;
  logic [NSRC-1:0]     sp_chips;
  logic [NSRC-1:0]     sp_vmask;
  logic [NDST*SW-1:0]  sp_sel;
  chip_tag_t           ch_tag;
  logic [SW-1:0]       ch_idx;
  logic                ch_bit;
  logic [NSRC-1:0]     ch_vmask;
  logic [NDST*SW-1:0]  ch_sel;
  logic                sp_vld;

  assign sp_vld = sp_tag.vld;

  sbc_spreader #(.NSRC(NSRC), .NDST(NDST), .SW(SW)) u_spread (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .rx_sel   (rx_sel),
    .sp_tag   (sp_tag),
    .sp_idx   (sp_idx),
    .sp_chips (sp_chips),
    .sp_vmask (sp_vmask),
    .sp_sel   (sp_sel)
  );

  sbc_channel #(.NSRC(NSRC), .NDST(NDST), .SW(SW)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_tag   (sp_tag),
    .sp_idx   (sp_idx),
    .sp_chips (sp_chips),
    .sp_vmask (sp_vmask),
    .sp_sel   (sp_sel),
    .ch_tag   (ch_tag),
    .ch_idx   (ch_idx),
    .ch_bit   (ch_bit),
    .ch_vmask (ch_vmask),
    .ch_sel   (ch_sel)
  );

  for (genvar r = 0; r < NDST; r++) begin : g_rx
    sbc_despreader #(.NSRC(NSRC), .SW(SW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_tag    (ch_tag),
      .ch_idx    (ch_idx),
      .ch_bit    (ch_bit),
      .ch_vmask  (ch_vmask),
      .sel       (ch_sel[r*SW +: SW]),
      .out_valid (out_valid[r]),
      .out_data  (out_data[r])
    );
  end

endmodule

// File: rtl/sbc_codec_chk.sv
module sbc_codec_chk #(
  parameter int NSRC = 4,
  parameter int NDST = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  in_valid,
  input logic             in_ready,
  input logic [NDST-1:0]  out_valid,
  input logic             sp_vld,
  input logic [NSRC-1:0]  sp_chips,
  input logic             ch_bit
);

  logic [NSRC+3:0] acc_hist;
  logic            took;

  assign took = in_ready && (|in_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) acc_hist <= '0;
    else        acc_hist <= {acc_hist[NSRC+2:0], took};
  end

  AST_ACCEPT_CLOSES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> !in_ready);  // R1

  AST_ONE_SENDER_PER_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sp_chips));  // R2

  AST_CHANNEL_EQUALS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    sp_vld |=> (ch_bit == $past(|sp_chips)));  // R3

  AST_OUT_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> acc_hist[NSRC+3]);  // R5

  AST_OUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |=> !(|out_valid));  // R6

endmodule

bind sbc_codec sbc_codec_chk #(.NSRC(NSRC), .NDST(NDST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .sp_vld    (sp_vld),
  .sp_chips  (sp_chips),
  .ch_bit    (ch_bit)
);

// File: tb/test_sbc_codec.sv
`timescale 1ns/1ps
module test_sbc_codec;
  localparam int P  = 4;
  localparam int D  = 4;
  localparam int SW = 2;
  localparam int LAT_NEG = P + 4;  // negedge offset from accept-cycle sample to visible output

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [P-1:0]     in_valid = '0;
  logic [P-1:0]     in_data = '0;
  logic             in_ready;
  logic [D*SW-1:0]  rx_sel = '0;
  logic [D-1:0]     out_valid;
  logic [D-1:0]     out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [D-1:0] exp_v [64];
  logic [D-1:0] exp_d [64];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  sbc_codec #(.NSRC(P), .NDST(D)) i_sbc_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rx_sel(rx_sel), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [D-1:0] exp_valid_f(input logic [P-1:0] v, input logic [D*SW-1:0] s);
    logic [D-1:0] e;
    for (int r = 0; r < D; r++) e[r] = v[s[r*SW +: SW]];
    return e;
  endfunction

  function automatic logic [D-1:0] exp_data_f(input logic [P-1:0] d, input logic [D*SW-1:0] s);
    logic [D-1:0] e;
    for (int r = 0; r < D; r++) e[r] = d[s[r*SW +: SW]];
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard: compare due outputs (R4, R5, R6, R8), then record new acceptances (sel sampled here, R7).
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = cyc % 64;
      if (exp_v[k] != '0 || out_valid != '0) begin
        check(out_valid == exp_v[k], "R5/R6 out_valid", int'(out_valid), int'(exp_v[k]));
        check(((out_data ^ exp_d[k]) & exp_v[k]) == '0, "R4/R8 out_data",
              int'(out_data & exp_v[k]), int'(exp_d[k] & exp_v[k]));
      end
      exp_v[k] = '0;
      exp_d[k] = '0;
      if (in_ready && (|in_valid)) begin
        k = (cyc + LAT_NEG) % 64;
        exp_v[k] = exp_valid_f(in_valid, rx_sel);
        exp_d[k] = exp_data_f(in_data, rx_sel);
      end
    end
  end

  // Offer one symbol and hold it until taken; scramble rx_sel afterwards (R7).
  task automatic send(input logic [P-1:0] vm, input logic [P-1:0] d, input logic [D*SW-1:0] s);
    in_valid = vm;
    in_data  = d;
    rx_sel   = s;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    rx_sel = (D*SW)'($urandom);
  endtask

  task automatic idle(input int n);
    in_valid = '0;
    in_data  = P'($urandom);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) begin exp_v[i] = '0; exp_d[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    check(out_valid == '0, "R9 reset out_valid", int'(out_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: ready while idle, closed for P-1 cycles after accept, reopens on last chip.
    in_valid = 4'b0001; in_data = 4'b0001; rx_sel = 8'h00;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 idle ready", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = '0;
    for (int n = 1; n < P; n++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R1 ready low during spreading", int'(in_ready), 0);
    end
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready on last chip", int'(in_ready), 1);
    @(posedge clk); #1;
    idle(P + 6);

    // R2/R3/R4: every permutation of receivers to sources, all senders active, back to back (R8).
    for (int a = 0; a < P; a++)
      for (int b = 0; b < P; b++)
        for (int c = 0; c < P; c++)
          for (int e = 0; e < P; e++)
            if (a != b && a != c && a != e && b != c && b != e && c != e)
              send('1, P'($urandom), {SW'(e), SW'(c), SW'(b), SW'(a)});
    idle(P + 6);

    // R6: silent senders carry garbage data; receivers on them must stay quiet.
    send(4'b0101, 4'b1010, {2'd3, 2'd2, 2'd1, 2'd0});
    send(4'b1000, 4'b0111, {2'd3, 2'd3, 2'd0, 2'd3});
    idle(P + 6);

    // Random mix of masks, data, selections (duplicates allowed) and gaps.
    for (int n = 0; n < 300; n++) begin
      send(P'($urandom), P'($urandom), (D*SW)'($urandom));
      if (($urandom % 5) == 0) idle(1 + ($urandom % 6));
    end
    idle(P + 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule